// File: doc/BRIEF.md
# Configurable Serial Bit Capture Shifter

This block reads a short burst of serial data from a single input pin and packs it into one result byte. It drives the serial clock itself, deriving it from the system clock through a programmable half-period divider. Each capture command picks three things: how many bits to read (one to eight), whether the first bit is the most significant or the least significant, and whether the pin is sampled on the rising or the falling edge of the serial clock.

A capture starts with a one-cycle `start` pulse while the block is idle. The block clears its shift register and runs one serial-clock period per bit. It then returns the clock to its low idle level and raises `result_valid` for one system cycle. The byte stays on `result` until the next command. Partial captures are not normalised. Most-significant-first data ends up right-justified. Least-significant-first data ends up left-justified.

The controller is a four-state machine. ST_IDLE goes to ST_LOW when a start is accepted. ST_LOW goes to ST_HIGH when its half-period expires. ST_HIGH goes back to ST_LOW when its half-period expires and more bits remain. ST_HIGH goes to ST_DONE when its half-period expires on the last bit. ST_DONE always goes back to ST_IDLE on the next cycle.

Top module: `bitcap_top`

## Requirements
- R1: After reset, `sclk`, `busy` and `result_valid` are low and `result` is zero.
- R2: `start` is acted on only in a cycle where `busy` is low. A pulse on `start` while a capture is running has no effect on that capture's result, clock timing or completion, and changes on `mode`, `nbits` and `half_div` during a capture are ignored.
- R3: `busy` goes high in the cycle after an accepted start. It stays high up to and including the `result_valid` cycle, and it is low in the cycle after that.
- R4: `sclk` idles low. During a capture each low phase and each high phase of `sclk` lasts `half_div`+1 system cycles, and `sclk` makes exactly as many rising edges as bits are captured.
- R5: `mode[0]`=1 selects falling-edge sampling and `mode[0]`=0 selects rising-edge sampling. `mode[1]`=1 selects least-significant-first and `mode[1]`=0 selects most-significant-first. `nbits` holds the bit count minus one, so 0 means one bit and 7 means eight bits.
- R6: In rising-edge modes, a bit is taken in the system cycle where the serial clock goes from low to high. In falling-edge modes, it is taken in the cycle where it goes from high to low. `sdi` passes through a two-flop synchroniser first, so the value used is the pin level two system cycles before that cycle.
- R7: Most-significant-first: each new bit enters bit 0 and earlier bits move up. After n bits, the first bit is in bit n-1 and the last bit is in bit 0.
- R8: Least-significant-first: each new bit enters bit 7 and earlier bits move down. After n bits, the first bit is in bit 8-n and the last bit is in bit 7. A one-bit capture lands in bit 7.
- R9: Result bits that the capture did not fill are zero, whatever earlier captures left behind.
- R10: `result_valid` is high for exactly one system cycle, and `sclk` is already low in that cycle. `result` holds its value after the pulse until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture request pulse, taken only when idle |
| mode | input | 2 | Bit 0: falling-edge sampling; bit 1: least-significant-first |
| nbits | input | 3 | Number of bits to capture, minus one |
| half_div | input | 8 | Serial-clock half-period, in system cycles, minus one |
| sdi | input | 1 | Serial data pin (asynchronous) |
| sclk | output | 1 | Generated serial clock, idles low |
| busy | output | 1 | Capture in progress |
| result_valid | output | 1 | One-cycle strobe when the result is ready |
| result | output | 8 | Captured byte |

## Verification
The assertions assume that `start` is a synchronous signal and that `half_div` is at least 2. With that setting, a level placed on `sdi` right after one serial-clock edge has passed through the synchroniser before the next sampling point. The bench follows the same rule. It changes `sdi` only in the cycle after it sees `sclk` change, and it uses half-periods of three or more system cycles. In the half-period that is not sampled, the bench drives the inverse of the intended bit. A capture on the wrong edge therefore gives a different byte.

// File: rtl/bitcap_pkg.sv
package bitcap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2,
        ST_DONE = 2'd3
    } cap_state_e;

    // field order matters: mode[1] = lsb_first, mode[0] = fall_edge
    typedef struct packed {
        logic lsb_first;
        logic fall_edge;
    } cap_mode_t;

endpackage

// File: rtl/bitcap_sync.sv
module bitcap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/bitcap_divider.sv
module bitcap_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] limit,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/bitcap_shreg.sv
module bitcap_shreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift_en,
    input  logic              lsb_first,
    input  logic              din,
    output logic [DATA_W-1:0] data
);
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (clear) begin
            data_q <= '0;
        end else if (shift_en) begin
            if (lsb_first) begin
                data_q <= {din, data_q[DATA_W-1:1]};
            end else begin
                data_q <= {data_q[DATA_W-2:0], din};
            end
        end
    end

    assign data = data_q;
endmodule

// File: rtl/bitcap_ctrl.sv
module bitcap_ctrl
    import bitcap_pkg::*;
#(
    parameter int CNT_W = 3,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       mode_in,
    input  logic [CNT_W-1:0] nbits_in,
    input  logic [DIV_W-1:0] half_in,
    input  logic             tick,
    output logic             sclk,
    output logic             busy,
    output logic             valid,
    output logic             run,
    output logic             clear,
    output logic             shift_en,
    output logic             lsb_first,
    output logic [DIV_W-1:0] half_lat
);
    cap_state_e       state_q, state_d;
    cap_mode_t        cfg_q;
    logic [CNT_W-1:0] last_q;
    logic [CNT_W-1:0] bit_q;
    logic [DIV_W-1:0] half_q;
    logic             sclk_q;
    logic             accept;
    logic             last_bit;

    assign accept   = start && (state_q == ST_IDLE);
    assign last_bit = (bit_q == last_q);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_LOW;
            ST_LOW:  if (tick)   state_d = ST_HIGH;
            ST_HIGH: if (tick)   state_d = last_bit ? ST_DONE : ST_LOW;
            ST_DONE:             state_d = ST_IDLE;
            default:             state_d = ST_IDLE;
        endcase
    end

    // state register and per-command context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            last_q  <= '0;
            bit_q   <= '0;
            half_q  <= '0;
            sclk_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            sclk_q  <= (state_d == ST_HIGH);
            if (accept) begin
                cfg_q  <= cap_mode_t'(mode_in);
                last_q <= nbits_in;
                half_q <= half_in;
                bit_q  <= '0;
            end else if ((state_q == ST_HIGH) && tick) begin
                bit_q  <= bit_q + 1'b1;
            end
        end
    end

    // output decode
    always_comb begin
        busy     = 1'b0;
        valid    = 1'b0;
        run      = 1'b0;
        clear    = 1'b0;
        shift_en = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                clear = accept;
            end
            ST_LOW: begin
                busy     = 1'b1;
                run      = 1'b1;
                shift_en = tick && !cfg_q.fall_edge;
            end
            ST_HIGH: begin
                busy     = 1'b1;
                run      = 1'b1;
                shift_en = tick && cfg_q.fall_edge;
            end
            ST_DONE: begin
                busy  = 1'b1;
                valid = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

    assign sclk      = sclk_q;
    assign lsb_first = cfg_q.lsb_first;
    assign half_lat  = half_q;
endmodule

// File: rtl/bitcap_top.sv
module bitcap_top #(
    parameter int DATA_W      = 8,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic [CNT_W-1:0]  nbits,
    input  logic [DIV_W-1:0]  half_div,
    input  logic              sdi,
    output logic              sclk,
    output logic              busy,
    output logic              result_valid,
    output logic [DATA_W-1:0] result
);
    logic             sdi_s;
    logic             tick;
    logic             run;
    logic             clear;
    logic             shift_en;
    logic             lsb_first;
    logic [DIV_W-1:0] half_lat;

    bitcap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sdi),
        .q     (sdi_s)
    );

    bitcap_divider #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .limit (half_lat),
        .tick  (tick)
    );

    bitcap_ctrl #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mode_in   (mode),
        .nbits_in  (nbits),
        .half_in   (half_div),
        .tick      (tick),
        .sclk      (sclk),
        .busy      (busy),
        .valid     (result_valid),
        .run       (run),
        .clear     (clear),
        .shift_en  (shift_en),
        .lsb_first (lsb_first),
        .half_lat  (half_lat)
    );

    bitcap_shreg #(.DATA_W(DATA_W)) u_shreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .shift_en  (shift_en),
        .lsb_first (lsb_first),
        .din       (sdi_s),
        .data      (result)
    );
endmodule

// File: rtl/bitcap_chk.sv
module bitcap_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [DIV_W-1:0] half_div,
    input logic             sclk,
    input logic             busy,
    input logic             result_valid
);
    logic [DIV_W-1:0] half_seen_q;
    logic [DIV_W:0]   hi_len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_seen_q <= '0;
            hi_len_q    <= '0;
        end else begin
            if (start && !busy) half_seen_q <= half_div;
            hi_len_q <= sclk ? hi_len_q + 1'b1 : '0;
        end
    end

    AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R3
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !result_valid) |=> busy); // R3
    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !busy); // R3
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid); // R10
    AST_VALID_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> !sclk); // R10
    AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk); // R4
    AST_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> (hi_len_q == ({1'b0, half_seen_q} + 1'b1))); // R4
    AST_VALID_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> busy); // R3
endmodule

bind bitcap_top bitcap_chk #(.DIV_W(DIV_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .half_div     (half_div),
    .sclk         (sclk),
    .busy         (busy),
    .result_valid (result_valid)
);

// File: tb/bitcap_top_tb.sv
module bitcap_top_tb;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [2:0] nbits = 3'd0;
    logic [7:0] half_div = 8'd2;
    logic       sdi = 1'b0;
    logic       sclk;
    logic       busy;
    logic       result_valid;
    logic [7:0] result;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    bitcap_top u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .mode         (mode),
        .nbits        (nbits),
        .half_div     (half_div),
        .sdi          (sdi),
        .sclk         (sclk),
        .busy         (busy),
        .result_valid (result_valid),
        .result       (result)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [7:0] expect_byte(input logic [1:0] md, input int n, input logic [7:0] pat);
        logic [7:0] e = 8'h00;
        for (int i = 0; i < n; i++) begin
            if (md[1]) e[8-n+i] = pat[i];  // R8 first bit at 8-n
            else       e[n-1-i] = pat[i];  // R7 first bit at n-1
        end
        return e;
    endfunction

    // bit k is held in the sampled half of period k, its inverse in the other half
    task automatic run_cap(input logic [1:0] md, input int n, input logic [7:0] pat,
                           input int h, input bit poke);
        logic [7:0] exp;
        logic       prev;
        int         len, rises, k, guard;
        bit         fall, done;
        fall = md[0];
        exp  = expect_byte(md, n, pat);
        @(negedge clk);
        mode     = md;
        nbits    = 3'(n - 1);
        half_div = 8'(h);
        sdi      = fall ? ~pat[0] : pat[0];
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R3 busy after accepted start", int'(busy), 1);
        prev = 1'b0; len = 0; rises = 0; k = 0; guard = 0; done = 0;
        while (!done) begin
            if (poke && guard == 3) begin
                start    = 1'b1;           // R2 ignored mid-capture
                mode     = ~md;
                nbits    = 3'(8 - n);
                half_div = 8'(h + 3);
            end else begin
                start = 1'b0;
            end
            if (sclk != prev) begin
                chk(len == h + 1, "R4 half-period length", len, h + 1);
                len = 1;
                if (sclk) begin
                    rises++;
                    sdi = fall ? pat[k] : ~pat[k];
                end else begin
                    k++;
                    sdi = (k < n) ? (fall ? ~pat[k] : pat[k]) : 1'b0;
                end
            end else begin
                len++;
            end
            prev = sclk;
            if (result_valid) begin
                chk(sclk == 1'b0, "R10 sclk low at valid", int'(sclk), 0);
                chk(busy == 1'b1, "R3 busy during valid", int'(busy), 1);
                chk(rises == n, "R4 rising edge count", rises, n);
                if (md[1]) chk(result == exp, "R8 R6 R5 R9 lsb-first result", int'(result), int'(exp));
                else       chk(result == exp, "R7 R6 R5 R9 msb-first result", int'(result), int'(exp));
                done = 1;
            end
            guard++;
            if (guard > 2000) begin
                chk(1'b0, "R3 capture never completed", guard, 0);
                done = 1;
            end
            if (!done) @(negedge clk);
        end
        start = 1'b0;
        @(negedge clk);
        chk(result_valid == 1'b0, "R10 valid lasts one cycle", int'(result_valid), 0);
        chk(busy == 1'b0, "R3 busy low after valid", int'(busy), 0);
        chk(result == exp, "R10 result held after valid", int'(result), int'(exp));
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog expired R3 actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] pats [4];
        pats[0] = 8'hA5; pats[1] = 8'h3C; pats[2] = 8'hFF; pats[3] = 8'h01;
        repeat (3) @(negedge clk);
        chk(sclk == 1'b0, "R1 reset sclk", int'(sclk), 0);
        chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
        chk(result_valid == 1'b0, "R1 reset valid", int'(result_valid), 0);
        chk(result == 8'h00, "R1 reset result", int'(result), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(sclk == 1'b0 && busy == 1'b0, "R1 idle after reset", int'({sclk, busy}), 0);

        // full sweep: every mode, every count, several data patterns
        for (int md = 0; md < 4; md++)
            for (int n = 1; n <= 8; n++)
                for (int p = 0; p < 4; p++)
                    run_cap(2'(md), n, pats[p], 2, 1'b0);

        // R9: a stale all-ones byte must not leak into a short capture
        run_cap(2'd0, 8, 8'hFF, 2, 1'b0);
        run_cap(2'd0, 1, 8'h00, 2, 1'b0);
        run_cap(2'd2, 8, 8'hFF, 2, 1'b0);
        run_cap(2'd2, 3, 8'h00, 2, 1'b0);

        // R4: a slower serial clock
        for (int md = 0; md < 4; md++)
            run_cap(2'(md), 5, 8'h16, 5, 1'b0);

        // R2: start and config changes during a capture are ignored
        for (int md = 0; md < 4; md++)
            run_cap(2'(md), 6, 8'h2D, 3, 1'b1);

        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && result_valid == 1'b0, "R2 no capture started by ignored pulse",
            int'({busy, result_valid}), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule